// File: doc/BRIEF.md
# Multi-Mode Tiered Interrupt Arbiter

This block gathers 48 interrupt request lines and selects one of them at a time to be in service. Sixteen of the lines are external requests, in two banks of eight (bank A and bank B). Sixteen report internal system errors and sixteen report internal clock errors. Each request is captured in a pending register. A granted request stays in service until the handler pulses `svc_done`. The grant is given as an index and a valid flag. Two aggregated lines, one for system errors and one for clock errors, tell the outside world which class of event needs attention.

An 8-bit mode input selects the behaviour at run time. In bypass mode no arbitration takes place, and the two aggregated lines simply follow the OR of the internal error inputs. In flat mode all 48 sources are equal and are served round-robin. The two tiered modes put clock errors above system errors, and system errors above both external banks, with round-robin service inside each tier. One tiered mode also lets a strictly higher tier take over the interrupt currently in service.

Top module: `irq_tier_arb`

## Requirements
- R1: While `rst` is high, at the next clock edge `grant_valid`, `grant_idx`, `sys_err_out` and `clk_err_out` all become 0, every pending request is cleared and every round-robin pointer returns to 0.
- R2: In bypass mode (`mode` = 8'h00) no request is granted and no request is kept pending. Switching into an arbitration mode afterwards produces no grant unless a new request arrives. Entering bypass while a grant is active withdraws that grant at the next edge.
- R3: In bypass mode, `sys_err_out` equals the OR of `sys_req` and `clk_err_out` equals the OR of `clk_req`, each delayed by one clock.
- R4: Source indices are fixed: bank A bit i is index i, bank B bit i is index 8+i, `sys_req` bit i is index 16+i and `clk_req` bit i is index 32+i. In flat mode (8'h01) the pending index chosen is the lowest one at or above a pointer, wrapping to the lowest one overall when none is at or above it. After each grant the pointer moves to one past the granted index, and from 47 it moves to 0.
- R5: In the tiered modes (8'h02 and 8'h12), when no grant is active the chosen tier is the highest one that has a pending request. Clock errors are the top tier, system errors the middle tier, and both external banks together form the bottom tier.
- R6: Inside each tier, selection is round-robin. Each tier has its own pointer, which moves to one past the granted position within that tier.
- R7: In flat mode and in mode 8'h02, a grant stays unchanged until `svc_done` retires it, whatever else becomes pending. In mode 8'h12 a new request from the same tier or a lower tier does not displace the grant.
- R8: In mode 8'h12, if a request from a tier strictly above the granted index's tier is pending and `svc_done` is low, the grant switches at the next edge to the winner of the highest pending tier.
- R9: A pre-empted request stays pending and is granted again later under normal arbitration.
- R10: Any `mode` value other than 8'h00, 8'h01, 8'h02 and 8'h12 behaves exactly as bypass.
- R11: A request is latched as pending at the clock edge where it is high. It can be granted at the next edge at the earliest. `svc_done` while a grant is valid clears that request's pending bit and drops `grant_valid` at the next edge, and a new arbitration follows one edge later. A request still high in the retire cycle stays pending. `grant_idx` reads 0 whenever `grant_valid` is 0.
- R12: In the arbitration modes, `clk_err_out` is high exactly when a grant with index 32 or above is valid. `sys_err_out` is high exactly when a grant with index below 32 is valid. Both update in the same edge as the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 8 | Arbitration mode code |
| ext_a_req | input | 8 | External request bank A |
| ext_b_req | input | 8 | External request bank B |
| sys_req | input | 16 | Internal system-error requests |
| clk_req | input | 16 | Internal clock-error requests |
| svc_done | input | 1 | One-cycle pulse that retires the current grant |
| grant_valid | output | 1 | A request is in service |
| grant_idx | output | 6 | Index of the request in service |
| sys_err_out | output | 1 | Aggregated system-error line |
| clk_err_out | output | 1 | Aggregated clock-error line |

## Verification
A request driven in cycle c becomes pending at the edge that ends c. Its earliest grant appears after the following edge, so a new request shows on the outputs two edges after it is first driven. A retire or a pre-emption shows one edge after the cycle in which it is driven, and the bypass OR lines also lag their inputs by one edge. The bench therefore drives each cycle's inputs at the falling edge, together with the output values expected just after the next rising edge. A monitor compares the outputs one nanosecond after every rising edge, so every expectation is tied to the edge that produces it, and the multi-cycle sequences are written out cycle by cycle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  typedef enum logic [1:0] {
    ARB_OFF,
    ARB_FLAT,
    ARB_TIER,
    ARB_PREEMPT
  } arb_mode_e;

  localparam logic [7:0] CODE_FLAT    = 8'h01;
  localparam logic [7:0] CODE_TIER    = 8'h02;
  localparam logic [7:0] CODE_PREEMPT = 8'h12;

  // Unknown codes fall back to bypass.
  function automatic arb_mode_e decode_mode(input logic [7:0] code);
    case (code)
      CODE_FLAT:    return ARB_FLAT;
      CODE_TIER:    return ARB_TIER;
      CODE_PREEMPT: return ARB_PREEMPT;
      default:      return ARB_OFF;
    endcase
  endfunction

endpackage

// File: rtl/irq_rr_pick.sv
module irq_rr_pick #(
  parameter int N = 16,
  parameter int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] ptr,
  output logic         found,
  output logic [W-1:0] idx
);

  logic         hi_hit;
  logic [W-1:0] hi_idx;
  logic [W-1:0] lo_idx;

  // Descending scan: the last hit kept is the lowest index.
  always_comb begin
    found  = 1'b0;
    hi_hit = 1'b0;
    hi_idx = '0;
    lo_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found  = 1'b1;
        lo_idx = W'(i);
        if (W'(i) >= ptr) begin
          hi_hit = 1'b1;
          hi_idx = W'(i);
        end
      end
    end
    idx = hi_hit ? hi_idx : lo_idx;
  end

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N  = 48,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_all,
  input  logic [N-1:0]  set_vec,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  pend
);

  logic [N-1:0] clr_mask;

  for (genvar g = 0; g < N; g++) begin : g_clr
    assign clr_mask[g] = clr_en && (clr_idx == IW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst || clr_all) pend <= '0;
    else                pend <= (pend & ~clr_mask) | set_vec;
  end

endmodule

// File: rtl/irq_tier_arb.sv
module irq_tier_arb
  import irq_arb_pkg::*;
#(
  parameter int EXT_W = 8,
  parameter int ERR_W = 16
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic [7:0]                               mode,
  input  logic [EXT_W-1:0]                         ext_a_req,
  input  logic [EXT_W-1:0]                         ext_b_req,
  input  logic [ERR_W-1:0]                         sys_req,
  input  logic [ERR_W-1:0]                         clk_req,
  input  logic                                     svc_done,
  output logic                                     grant_valid,
  output logic [$clog2(2*EXT_W+2*ERR_W)-1:0]       grant_idx,
  output logic                                     sys_err_out,
  output logic                                     clk_err_out
);

  localparam int N_EXT    = 2 * EXT_W;
  localparam int N_ALL    = N_EXT + 2 * ERR_W;
  localparam int IW       = $clog2(N_ALL);
  localparam int EW       = $clog2(N_EXT);
  localparam int RW       = $clog2(ERR_W);
  localparam int SYS_BASE = N_EXT;
  localparam int CLK_BASE = N_EXT + ERR_W;

  localparam logic [IW-1:0] SYS_BASE_I = IW'(SYS_BASE);
  localparam logic [IW-1:0] CLK_BASE_I = IW'(CLK_BASE);
  localparam logic [IW-1:0] LAST_I     = IW'(N_ALL - 1);
  localparam logic [EW-1:0] EXT_LAST   = EW'(N_EXT - 1);
  localparam logic [RW-1:0] ERR_LAST   = RW'(ERR_W - 1);

  arb_mode_e      mode_dec;
  logic [N_ALL-1:0] req_all;
  logic [N_ALL-1:0] pend_q;

  logic          gnt_v_q, gnt_v_n;
  logic [IW-1:0] gnt_idx_q, gnt_idx_n;
  logic          sys_o_n, clk_o_n;

  logic [IW-1:0] flat_ptr_q, flat_ptr_n;
  logic [EW-1:0] ext_ptr_q, ext_ptr_n;
  logic [RW-1:0] err_ptr_q [2];
  logic [RW-1:0] err_ptr_n [2];

  logic          f_found;
  logic [IW-1:0] f_idx;
  logic          x_found;
  logic [EW-1:0] x_idx;
  logic [1:0]    e_found;
  logic [RW-1:0] e_idx [2];

  logic          t_found;
  logic [IW-1:0] t_idx;
  logic [1:0]    t_tier;
  logic [1:0]    cur_tier;

  logic          take;
  logic [IW-1:0] win_idx;
  logic [1:0]    win_tier;

  assign mode_dec = decode_mode(mode);
  assign req_all  = {clk_req, sys_req, ext_b_req, ext_a_req};

  irq_pend_bank #(.N(N_ALL), .IW(IW)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .clr_all (mode_dec == ARB_OFF),
    .set_vec (req_all),
    .clr_en  (gnt_v_q && svc_done),
    .clr_idx (gnt_idx_q),
    .pend    (pend_q)
  );

  irq_rr_pick #(.N(N_ALL), .W(IW)) u_flat_pick (
    .req   (pend_q),
    .ptr   (flat_ptr_q),
    .found (f_found),
    .idx   (f_idx)
  );

  irq_rr_pick #(.N(N_EXT), .W(EW)) u_ext_pick (
    .req   (pend_q[N_EXT-1:0]),
    .ptr   (ext_ptr_q),
    .found (x_found),
    .idx   (x_idx)
  );

  // Tier 1 (g=0) is system errors, tier 2 (g=1) is clock errors.
  for (genvar g = 0; g < 2; g++) begin : g_err_tier
    irq_rr_pick #(.N(ERR_W), .W(RW)) u_err_pick (
      .req   (pend_q[SYS_BASE + g*ERR_W +: ERR_W]),
      .ptr   (err_ptr_q[g]),
      .found (e_found[g]),
      .idx   (e_idx[g])
    );
  end

  // Highest non-empty tier wins.
  always_comb begin
    t_found = 1'b1;
    t_idx   = '0;
    t_tier  = 2'd0;
    if (e_found[1]) begin
      t_idx  = CLK_BASE_I + IW'(e_idx[1]);
      t_tier = 2'd2;
    end else if (e_found[0]) begin
      t_idx  = SYS_BASE_I + IW'(e_idx[0]);
      t_tier = 2'd1;
    end else if (x_found) begin
      t_idx  = IW'(x_idx);
      t_tier = 2'd0;
    end else begin
      t_found = 1'b0;
    end
  end

  always_comb begin
    if (gnt_idx_q >= CLK_BASE_I)      cur_tier = 2'd2;
    else if (gnt_idx_q >= SYS_BASE_I) cur_tier = 2'd1;
    else                              cur_tier = 2'd0;
  end

  // Grant decision.
  always_comb begin
    take      = 1'b0;
    win_idx   = (mode_dec == ARB_FLAT) ? f_idx : t_idx;
    win_tier  = t_tier;
    gnt_v_n   = gnt_v_q;
    gnt_idx_n = gnt_idx_q;
    if (mode_dec == ARB_OFF) begin
      gnt_v_n   = 1'b0;
      gnt_idx_n = '0;
    end else if (gnt_v_q && svc_done) begin
      gnt_v_n   = 1'b0;
      gnt_idx_n = '0;
    end else if (gnt_v_q) begin
      if (mode_dec == ARB_PREEMPT && t_found && (t_tier > cur_tier))
        take = 1'b1;
    end else begin
      take = (mode_dec == ARB_FLAT) ? f_found : t_found;
    end
    if (take) begin
      gnt_v_n   = 1'b1;
      gnt_idx_n = win_idx;
    end
  end

  // Pointer advance: one past the granted position in the affected group.
  always_comb begin
    flat_ptr_n   = flat_ptr_q;
    ext_ptr_n    = ext_ptr_q;
    err_ptr_n[0] = err_ptr_q[0];
    err_ptr_n[1] = err_ptr_q[1];
    if (take) begin
      if (mode_dec == ARB_FLAT) begin
        flat_ptr_n = (win_idx == LAST_I) ? '0 : win_idx + 1'b1;
      end else begin
        case (win_tier)
          2'd2:    err_ptr_n[1] = (e_idx[1] == ERR_LAST) ? '0 : e_idx[1] + 1'b1;
          2'd1:    err_ptr_n[0] = (e_idx[0] == ERR_LAST) ? '0 : e_idx[0] + 1'b1;
          default: ext_ptr_n    = (x_idx == EXT_LAST) ? '0 : x_idx + 1'b1;
        endcase
      end
    end
  end

  always_comb begin
    if (mode_dec == ARB_OFF) begin
      sys_o_n = |sys_req;
      clk_o_n = |clk_req;
    end else begin
      sys_o_n = gnt_v_n && (gnt_idx_n < CLK_BASE_I);
      clk_o_n = gnt_v_n && (gnt_idx_n >= CLK_BASE_I);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_v_q      <= 1'b0;
      gnt_idx_q    <= '0;
      sys_err_out  <= 1'b0;
      clk_err_out  <= 1'b0;
      flat_ptr_q   <= '0;
      ext_ptr_q    <= '0;
      err_ptr_q[0] <= '0;
      err_ptr_q[1] <= '0;
    end else begin
      gnt_v_q      <= gnt_v_n;
      gnt_idx_q    <= gnt_idx_n;
      sys_err_out  <= sys_o_n;
      clk_err_out  <= clk_o_n;
      flat_ptr_q   <= flat_ptr_n;
      ext_ptr_q    <= ext_ptr_n;
      err_ptr_q[0] <= err_ptr_n[0];
      err_ptr_q[1] <= err_ptr_n[1];
    end
  end

  assign grant_valid = gnt_v_q;
  assign grant_idx   = gnt_idx_q;

  // Assertions next to the logic they guard.
  assert_off_no_grant_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_dec == ARB_OFF) |=> !grant_valid);

  assert_retire_drops_R11: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && svc_done) |=> !grant_valid);

  assert_grant_is_pending_R11: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> pend_q[grant_idx]);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && !svc_done && (mode_dec == ARB_FLAT || mode_dec == ARB_TIER))
      |=> (grant_valid && $stable(grant_idx)));

  assert_preempt_clk_R8: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && !svc_done && mode_dec == ARB_PREEMPT &&
     (|pend_q[CLK_BASE +: ERR_W]) && grant_idx < CLK_BASE_I)
      |=> (grant_valid && grant_idx >= CLK_BASE_I));

  assert_lines_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> !(sys_err_out && clk_err_out));

endmodule

// File: tb/test_irq_tier_arb.sv
module test_irq_tier_arb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mode = 8'h00;
  logic [7:0]  ext_a_req = '0;
  logic [7:0]  ext_b_req = '0;
  logic [15:0] sys_req = '0;
  logic [15:0] clk_req = '0;
  logic        svc_done = 1'b0;
  logic        grant_valid;
  logic [5:0]  grant_idx;
  logic        sys_err_out;
  logic        clk_err_out;

  localparam logic [7:0] M_OFF = 8'h00, M_FLAT = 8'h01, M_TIER = 8'h02, M_PRE = 8'h12;

  typedef struct {
    logic [8:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_tier_arb i_irq_tier_arb (
    .clk         (clk),
    .rst         (rst),
    .mode        (mode),
    .ext_a_req   (ext_a_req),
    .ext_b_req   (ext_b_req),
    .sys_req     (sys_req),
    .clk_req     (clk_req),
    .svc_done    (svc_done),
    .grant_valid (grant_valid),
    .grant_idx   (grant_idx),
    .sys_err_out (sys_err_out),
    .clk_err_out (clk_err_out)
  );

  // Driver: one cycle of inputs plus the outputs expected after the next edge.
  task automatic step(input logic [7:0] m, input logic [7:0] a, input logic [7:0] b,
                      input logic [15:0] s, input logic [15:0] c, input logic d,
                      input logic v, input logic [5:0] ix, input logic so,
                      input logic co, input string tag);
    item_t it;
    @(negedge clk);
    mode = m; ext_a_req = a; ext_b_req = b; sys_req = s; clk_req = c; svc_done = d;
    it.exp = {v, ix, so, co};
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input logic [7:0] m, input logic v, input logic [5:0] ix,
                      input logic so, input logic co, input string tag);
    step(m, 8'h00, 8'h00, 16'h0, 16'h0, 1'b0, v, ix, so, co, tag);
  endtask

  task automatic retire(input logic [7:0] m, input string tag);
    step(m, 8'h00, 8'h00, 16'h0, 16'h0, 1'b1, 1'b0, 6'd0, 1'b0, 1'b0, tag);
  endtask

  // Monitor: compare one item per edge, 1 ns after the rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        logic [8:0] act;
        it  = q.pop_front();
        act = {grant_valid, grant_idx, sys_err_out, clk_err_out};
        n_vec++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual v=%0b idx=%0d sys=%0b clk=%0b expected v=%0b idx=%0d sys=%0b clk=%0b",
                   it.tag, act[8], act[7:2], act[1], act[0],
                   it.exp[8], it.exp[7:2], it.exp[1], it.exp[0]);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset with busy inputs
    step(M_FLAT, 8'hff, 8'hff, 16'hffff, 16'hffff, 1'b0, 0, 0, 0, 0, "R1 reset");
    step(M_FLAT, 8'hff, 8'hff, 16'hffff, 16'hffff, 1'b0, 0, 0, 0, 0, "R1 reset");
    @(negedge clk); rst = 1'b0;
    idle(M_OFF, 0, 0, 0, 0, "R1 after reset");

    // R3 / R2 bypass
    step(M_OFF, 8'hff, 8'hff, 16'h0001, 16'h0, 1'b0, 0, 0, 1, 0, "R3 sys OR");
    step(M_OFF, 8'h00, 8'h00, 16'h0, 16'h8000, 1'b0, 0, 0, 0, 1, "R3 clk OR");
    idle(M_FLAT, 0, 0, 0, 0, "R2 nothing kept");
    idle(M_FLAT, 0, 0, 0, 0, "R2 nothing kept");

    // R4 flat round robin, R11 latency/retire, R12 lines
    step(M_FLAT, 8'h01, 8'h00, 16'h0001, 16'h0001, 1'b0, 0, 0, 0, 0, "R11 latch only");
    idle(M_FLAT, 1, 6'd0, 1, 0, "R4 flat first");
    retire(M_FLAT, "R11 retire");
    idle(M_FLAT, 1, 6'd16, 1, 0, "R4 flat next");
    retire(M_FLAT, "R11 retire");
    idle(M_FLAT, 1, 6'd32, 0, 1, "R12 clk line");
    retire(M_FLAT, "R11 retire");
    idle(M_FLAT, 0, 0, 0, 0, "R11 empty");
    step(M_FLAT, 8'h01, 8'h00, 16'h0, 16'h0100, 1'b0, 0, 0, 0, 0, "R11 latch only");
    idle(M_FLAT, 1, 6'd40, 0, 1, "R4 pointer past 32");
    retire(M_FLAT, "R11 retire");
    idle(M_FLAT, 1, 6'd0, 1, 0, "R4 wrap");
    retire(M_FLAT, "R11 retire");

    // R5 tiers, R7 hold without pre-emption
    step(M_TIER, 8'h02, 8'h00, 16'h0004, 16'h0002, 1'b0, 0, 0, 0, 0, "R11 latch only");
    idle(M_TIER, 1, 6'd33, 0, 1, "R5 clk tier first");
    retire(M_TIER, "R11 retire");
    idle(M_TIER, 1, 6'd18, 1, 0, "R5 sys tier next");
    step(M_TIER, 8'h00, 8'h00, 16'h0, 16'h0001, 1'b0, 1, 6'd18, 1, 0, "R7 hold");
    idle(M_TIER, 1, 6'd18, 1, 0, "R7 hold no preempt");
    retire(M_TIER, "R11 retire");
    idle(M_TIER, 1, 6'd32, 0, 1, "R6 clk tier wrap");
    retire(M_TIER, "R11 retire");
    idle(M_TIER, 1, 6'd1, 1, 0, "R5 ext tier last");
    retire(M_TIER, "R11 retire");
    step(M_TIER, 8'h00, 8'h00, 16'h0003, 16'h0, 1'b0, 0, 0, 0, 0, "R11 latch only");
    idle(M_TIER, 1, 6'd16, 1, 0, "R6 sys wrap");
    retire(M_TIER, "R11 retire");
    idle(M_TIER, 1, 6'd17, 1, 0, "R6 sys next");
    retire(M_TIER, "R11 retire");

    // R8 / R9 pre-emption
    step(M_PRE, 8'h80, 8'h00, 16'h0, 16'h0, 1'b0, 0, 0, 0, 0, "R11 latch only");
    idle(M_PRE, 1, 6'd7, 1, 0, "R8 ext granted");
    step(M_PRE, 8'h00, 8'h00, 16'h0100, 16'h0, 1'b0, 1, 6'd7, 1, 0, "R8 before preempt");
    idle(M_PRE, 1, 6'd24, 1, 0, "R8 sys preempts ext");
    step(M_PRE, 8'h00, 8'h00, 16'h0, 16'h0010, 1'b0, 1, 6'd24, 1, 0, "R8 before preempt");
    idle(M_PRE, 1, 6'd36, 0, 1, "R8 clk preempts sys");
    retire(M_PRE, "R11 retire");
    idle(M_PRE, 1, 6'd24, 1, 0, "R9 sys regranted");
    retire(M_PRE, "R11 retire");
    idle(M_PRE, 1, 6'd7, 1, 0, "R9 ext regranted");
    step(M_PRE, 8'h00, 8'h01, 16'h0, 16'h0, 1'b0, 1, 6'd7, 1, 0, "R7 same tier");
    idle(M_PRE, 1, 6'd7, 1, 0, "R7 same tier hold");
    retire(M_PRE, "R11 retire");
    idle(M_PRE, 1, 6'd8, 1, 0, "R6 bank B after");
    retire(M_PRE, "R11 retire");

    // R10 unknown code
    step(8'h05, 8'h00, 8'h00, 16'h0002, 16'h0, 1'b0, 0, 0, 1, 0, "R10 acts as bypass");
    step(8'h05, 8'hff, 8'hff, 16'h0, 16'h0, 1'b0, 0, 0, 0, 0, "R10 no latch");
    idle(M_FLAT, 0, 0, 0, 0, "R10 nothing kept");
    idle(M_FLAT, 0, 0, 0, 0, "R10 nothing kept");

    // R2 bypass withdraws active grant
    step(M_FLAT, 8'h00, 8'h00, 16'h0, 16'h0001, 1'b0, 0, 0, 0, 0, "R11 latch only");
    idle(M_FLAT, 1, 6'd32, 0, 1, "R4 flat grant");
    idle(M_OFF, 0, 0, 0, 0, "R2 withdraw");
    idle(M_FLAT, 0, 0, 0, 0, "R2 cleared");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule